// File: doc/BRIEF.md
# Nibble Burst Sequencer

This block sits beside a DRAM core and turns one ordinary access into a short burst of up to four bits, and more if the burst wraps. It samples the row strobe, column strobe and write-enable strobe (all active low) on the system clock. When the row strobe falls it captures one row-side selector bit. On the first column-strobe fall inside that row period it captures one column-side selector bit. These two bits form the starting nibble index. Every later high-to-low toggle of the column strobe, with the row strobe still low, steps the index by one without any new address. The core keeps all the other address bits and the storage array. It uses the index to pick the cell, the write strobe to update it, and the drive flag to enable its data output.

The output behaviour for the whole burst is fixed at the first column-strobe fall. If write-enable is low at that moment (an early write), the data output stays high-impedance for the entire burst. If it is high (a read, or a delayed write that comes later), the output drives the selected cell on every column-low cycle of the burst. Writes are not frozen. Any column-low cycle with write-enable low raises the write strobe, so each bit of the burst can be written or skipped on its own. Because the index revisits each bit, a bit that was written earlier in the burst is read back with its new value by the core.

States: `ST_IDLE` (row strobe high), `ST_ROW_OPEN` (row open, waiting for the first column fall), `ST_FIRST_ACC` (first, normal access), `ST_NIB_PRE` (column high between nibbles), `ST_NIB_ACC` (nibble access). Transitions: open-row (IDLE to ROW_OPEN on row fall), first-access (ROW_OPEN to FIRST_ACC on column fall; loads index and mode), first-release (FIRST_ACC to NIB_PRE on column rise), nibble-step (NIB_PRE to NIB_ACC on column fall; increments index), nibble-release (NIB_ACC to NIB_PRE on column rise), close-row (any non-idle state to IDLE on row rise; takes priority).

Top module: `nib_burst_seq`

## Requirements
- R1: After reset, `nib_idx` is 0 and `out_drive`, `wr_stb` and `burst_mode` are all 0.
- R2: The first access of a row period loads `nib_idx` = {row selector, column selector}, with the column selector as bit 0. The row selector is taken when the row strobe falls and the column selector at the first column fall.
- R3: Each later column fall while the row strobe stays low increments `nib_idx` by one modulo 4 (3 wraps to 0). The sequence repeats for bursts longer than four.
- R4: While the row strobe is high, column-strobe toggles have no effect: `nib_idx` holds its last value and `out_drive` and `wr_stb` stay 0.
- R5: If write-enable is low at the first column fall, `burst_mode` is 0 and `out_drive` stays 0 for the whole burst, whatever write-enable does later.
- R6: If write-enable is high at the first column fall, `burst_mode` is 1. `out_drive` is then 1 in every column-low cycle of the burst and 0 while the column strobe is high, whatever write-enable does later.
- R7: `wr_stb` is 1 exactly in column-low access cycles (first or nibble) of an open row in which write-enable is low. This holds for both burst modes.
- R8: A row-strobe rise ends the burst and clears `burst_mode`. The next burst takes its start index and its mode afresh.
- R9: Each output reflects a strobe change two clock edges after the change is applied: one sampling stage, then one state update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| row_nib_bit | input | 1 | Row-side nibble selector bit |
| col_nib_bit | input | 1 | Column-side nibble selector bit |
| nib_idx | output | 2 | Current nibble index, column bit in bit 0 |
| wr_stb | output | 1 | Write strobe for the selected bit |
| out_drive | output | 1 | Data output enable for the selected bit |
| burst_mode | output | 1 | Frozen burst mode: 1 drive, 0 high-impedance |

## Verification
A wrong start index or step shows on `nib_idx` two edges after the column fall that caused it, and it stays wrong for every following nibble. A mode captured from the wrong write-enable sample shows as `out_drive` stuck on or off in the first access cycle and in every later column-low cycle. A missed row-rise clear shows on `burst_mode` two edges after the row strobe rises. A write strobe in the wrong place shows in the same cycle in which the access state and write-enable disagree. The sweep covers every start index, both modes, burst lengths up to six, and changes of write-enable during the burst.

// File: rtl/nib_pkg.sv
package nib_pkg;
    localparam int NIB_W   = 2;
    localparam int STRB_N  = 3;
    localparam int S_RAS   = 0;
    localparam int S_CAS   = 1;
    localparam int S_WE    = 2;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_ROW_OPEN  = 3'd1,
        ST_FIRST_ACC = 3'd2,
        ST_NIB_PRE   = 3'd3,
        ST_NIB_ACC   = 3'd4
    } nib_state_e;
endpackage

// File: rtl/nib_strobe_sync.sv
module nib_strobe_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_n,
    output logic [N-1:0] lvl_n,
    output logic [N-1:0] fall,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_n;

    for (genvar i = 0; i < N; i++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lvl_n[i]  <= 1'b1;
                prev_n[i] <= 1'b1;
            end else begin
                lvl_n[i]  <= raw_n[i];
                prev_n[i] <= lvl_n[i];
            end
        end
        assign fall[i] = prev_n[i] & ~lvl_n[i];
        assign rise[i] = ~prev_n[i] & lvl_n[i];
    end
endmodule

// File: rtl/nib_index_ctr.sv
module nib_index_ctr #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] idx
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx <= '0;
        else if (load)
            idx <= load_val;
        else if (step)
            idx <= idx + ONE;
    end
endmodule

// File: rtl/nib_mode_latch.sv
module nib_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic drive_val,
    input  logic clear,
    output logic mode
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode <= 1'b0;
        else if (clear)
            mode <= 1'b0;
        else if (capture)
            mode <= drive_val;
    end
endmodule

// File: rtl/nib_burst_seq.sv
module nib_burst_seq
    import nib_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic             row_nib_bit,
    input  logic             col_nib_bit,
    output logic [NIB_W-1:0] nib_idx,
    output logic             wr_stb,
    output logic             out_drive,
    output logic             burst_mode
);
    logic [STRB_N-1:0] raw_n, lvl_n, fall, rise;
    logic ras_fall, ras_rise, cas_fall, cas_rise, we_lvl_n;
    nib_state_e st, st_nx;
    logic row_lat;
    logic ld_idx, step_idx, cap_mode, clr_mode, in_acc;

    assign raw_n[S_RAS] = ras_n;
    assign raw_n[S_CAS] = cas_n;
    assign raw_n[S_WE]  = we_n;

    nib_strobe_sync #(.N(STRB_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_n (raw_n),
        .lvl_n (lvl_n),
        .fall  (fall),
        .rise  (rise)
    );

    assign ras_fall = fall[S_RAS];
    assign ras_rise = rise[S_RAS];
    assign cas_fall = fall[S_CAS];
    assign cas_rise = rise[S_CAS];
    assign we_lvl_n = lvl_n[S_WE];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= ST_IDLE;
        else
            st <= st_nx;
    end

    // row selector captured at row open
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            row_lat <= 1'b0;
        else if (st == ST_IDLE && ras_fall)
            row_lat <= row_nib_bit;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:      if (ras_fall) st_nx = ST_ROW_OPEN;
            ST_ROW_OPEN:  if (ras_rise) st_nx = ST_IDLE;
                          else if (cas_fall) st_nx = ST_FIRST_ACC;
            ST_FIRST_ACC: if (ras_rise) st_nx = ST_IDLE;
                          else if (cas_rise) st_nx = ST_NIB_PRE;
            ST_NIB_PRE:   if (ras_rise) st_nx = ST_IDLE;
                          else if (cas_fall) st_nx = ST_NIB_ACC;
            ST_NIB_ACC:   if (ras_rise) st_nx = ST_IDLE;
                          else if (cas_rise) st_nx = ST_NIB_PRE;
            default:      st_nx = ST_IDLE;
        endcase
    end

    // transition controls
    always_comb begin
        ld_idx   = 1'b0;
        step_idx = 1'b0;
        cap_mode = 1'b0;
        clr_mode = 1'b0;
        unique case (st)
            ST_IDLE:      clr_mode = 1'b1;
            ST_ROW_OPEN:  begin
                              clr_mode = ras_rise;
                              ld_idx   = !ras_rise && cas_fall;
                              cap_mode = !ras_rise && cas_fall;
                          end
            ST_FIRST_ACC: clr_mode = ras_rise;
            ST_NIB_PRE:   begin
                              clr_mode = ras_rise;
                              step_idx = !ras_rise && cas_fall;
                          end
            ST_NIB_ACC:   clr_mode = ras_rise;
            default:      clr_mode = 1'b1;
        endcase
    end

    nib_index_ctr #(.W(NIB_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_idx),
        .load_val ({row_lat, col_nib_bit}),
        .step     (step_idx),
        .idx      (nib_idx)
    );

    nib_mode_latch u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (cap_mode),
        .drive_val (we_lvl_n),
        .clear     (clr_mode),
        .mode      (burst_mode)
    );

    // outputs
    always_comb begin
        in_acc = 1'b0;
        unique case (st)
            ST_FIRST_ACC, ST_NIB_ACC: in_acc = 1'b1;
            default:                  in_acc = 1'b0;
        endcase
        out_drive = in_acc && burst_mode;
        wr_stb    = in_acc && !we_lvl_n;
    end
endmodule

// File: rtl/nib_burst_chk.sv
module nib_burst_chk
    import nib_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input nib_state_e       st,
    input logic             ras_rise,
    input logic             cas_fall,
    input logic             row_lat,
    input logic             col_nib_bit,
    input logic [NIB_W-1:0] nib_idx,
    input logic             wr_stb,
    input logic             out_drive,
    input logic             burst_mode
);
    assert_start_idx_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ROW_OPEN && cas_fall && !ras_rise) |=>
            nib_idx == {$past(row_lat), $past(col_nib_bit)});

    assert_step_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_NIB_PRE && cas_fall && !ras_rise) |=>
            nib_idx == $past(nib_idx) + 2'd1);

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (!out_drive && !wr_stb && !burst_mode));

    assert_hiz_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_mode |-> !out_drive);

    assert_mode_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_FIRST_ACC || st == ST_NIB_PRE || st == ST_NIB_ACC) && !ras_rise)
            |=> $stable(burst_mode));

    assert_write_in_acc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (st == ST_FIRST_ACC || st == ST_NIB_ACC));

    assert_close_row_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_rise && st != ST_IDLE) |=> (st == ST_IDLE && !burst_mode));
endmodule

bind nib_burst_seq nib_burst_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .st          (st),
    .ras_rise    (ras_rise),
    .cas_fall    (cas_fall),
    .row_lat     (row_lat),
    .col_nib_bit (col_nib_bit),
    .nib_idx     (nib_idx),
    .wr_stb      (wr_stb),
    .out_drive   (out_drive),
    .burst_mode  (burst_mode)
);

// File: tb/sim_nib_burst_seq.sv
`timescale 1ns/1ps
module sim_nib_burst_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic row_nib_bit = 1'b0, col_nib_bit = 1'b0;
    logic [1:0] nib_idx;
    logic wr_stb, out_drive, burst_mode;
    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    nib_burst_seq u0 (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .row_nib_bit(row_nib_bit), .col_nib_bit(col_nib_bit),
        .nib_idx(nib_idx), .wr_stb(wr_stb), .out_drive(out_drive),
        .burst_mode(burst_mode)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // two edges: sampling stage plus state update (R9)
    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic burst(input int r, input int c, input int we_first, input int len,
                         input int we_pat);
        int start;
        int mode;
        start = r * 2 + c;
        mode  = we_first;
        @(negedge clk);
        row_nib_bit = r[0];
        ras_n = 1'b0;
        settle();
        row_nib_bit = ~r[0];
        col_nib_bit = c[0];
        we_n  = we_first[0];
        cas_n = 1'b0;
        settle();
        chk("R2", "start idx", nib_idx, start);
        chk("R9", "mode after first fall", burst_mode, mode);
        chk(mode ? "R6" : "R5", "drive first", out_drive, mode);
        chk("R7", "wr first", wr_stb, !we_first);
        if (mode == 1) begin
            we_n = 1'b0;
            settle();
            chk("R7", "delayed write strobe", wr_stb, 1);
            chk("R6", "drive after late we", out_drive, 1);
        end
        for (int k = 1; k < len; k++) begin
            int wb;
            wb = (we_pat >> k) & 1;
            cas_n = 1'b1;
            we_n  = 1'b1;
            settle();
            chk("R6", "drive precharge", out_drive, 0);
            chk("R7", "wr precharge", wr_stb, 0);
            we_n  = wb[0];
            cas_n = 1'b0;
            settle();
            chk("R3", "nibble idx", nib_idx, (start + k) % 4);
            chk(mode ? "R6" : "R5", "drive nibble", out_drive, mode);
            chk("R7", "wr nibble", wr_stb, !wb);
            chk("R5", "mode held", burst_mode, mode);
        end
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        settle();
        chk("R8", "mode cleared", burst_mode, 0);
        // column toggles with row closed
        cas_n = 1'b0;
        we_n  = 1'b0;
        settle();
        chk("R4", "idx held", nib_idx, (start + len - 1) % 4);
        chk("R4", "no drive", out_drive, 0);
        chk("R4", "no write", wr_stb, 0);
        cas_n = 1'b1;
        we_n  = 1'b1;
        settle();
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "idx reset", nib_idx, 0);
        chk("R1", "drive reset", out_drive, 0);
        chk("R1", "wr reset", wr_stb, 0);
        chk("R1", "mode reset", burst_mode, 0);
        rst_n = 1'b1;
        settle();
        for (int r = 0; r < 2; r++)
            for (int c = 0; c < 2; c++)
                for (int w = 0; w < 2; w++)
                    for (int len = 1; len <= 6; len++)
                        burst(r, c, w, len, (r * 37 + c * 11 + len * 5 + w) & 63);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule